// File: doc/BRIEF.md
# Rank Threshold Quantizer

This block decides, for one bit-slice of a sample window, whether at least `r` of the window's samples hold a one in the current bit position. It is the decision element of a bit-serial rank-order filter. The filter walks the sample bits from the most significant downwards. At each step it presents the slice of that bit column and the wanted rank, and it takes one result bit back. That bit is the filter output's bit for the column, and it also steers the polarization of the samples that are no longer candidates.

The slice goes through a tree of half and full adder cells, which yields its population count `Z`. The count is as wide as needed to represent `N` itself. The comparison against the rank uses no subtractor. A chain of majority cells produces only the final carry of `Z + ~r + 1`, and that carry is 1 exactly when `Z >= r`. The carry-in of the lowest stage is the constant 1, so that stage reduces to an OR of `Z[0]` with the inverted `r[0]`.

The parameter `PIPE_STAGES` selects one of two variants. With the value 1 (the default), a register sits between the adder tree and the carry chain and the rank is registered beside the count. With the value 0 the block is purely combinational. The pipeline register uses an active-low asynchronous reset that clears both the count and the rank. No state machine is involved: the only state is that one optional register stage, which has the states "reset" and "holding the previous cycle's count and rank".

Top module: `rank_threshold_quantizer`

## Requirements
- R1: With `PIPE_STAGES`=1, `at_least_o` after a rising clock edge (reset released) equals 1 exactly when the number of ones in the `slice_i` captured at that edge is greater than or equal to the unsigned value of `rank_i` captured at that edge.
- R2: With `PIPE_STAGES`=1 the result has a latency of exactly one clock edge. A change of `slice_i` or `rank_i` leaves `at_least_o` unchanged until the next rising edge, and the new result is present right after that edge.
- R3: A rank of 0 gives `at_least_o` = 1 for every slice, including the all-zero slice.
- R4: A rank greater than `N` (the values `N+1` up to `2^W-1`, where W = ceil(log2(N+1))) gives `at_least_o` = 0 for every slice, including the all-ones slice.
- R5: At the upper boundary, the all-ones slice with rank `N` gives 1, and any slice with `N-1` ones with rank `N` gives 0.
- R6: While `rst_n` is low, the stored count and rank are both zero, so `at_least_o` is 1 whatever `slice_i` and `rank_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline register |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline register |
| slice_i | input | N | One bit column of the sample window, one bit per sample |
| rank_i | input | W = ceil(log2(N+1)) | Wanted rank, unsigned |
| at_least_o | output | 1 | 1 when the slice holds at least `rank_i` ones |

## Verification
A fault in the adder tree or in a carry cell shows up at `at_least_o` for the first slice and rank pair whose count sits on the wrong side of the threshold. It appears one edge after that pair is presented. The bench therefore sweeps every one of the 512 slices against every representable rank and compares the output on every clock. A wrong count bit or a broken majority stage cannot escape that sweep. A fault in the register stage or its reset shows up as a result that arrives one cycle early or one cycle late, or as a 0 during reset. The latency and reset checks target these faults directly.

// File: rtl/rtq_pkg.sv
package rtq_pkg;

    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Three-input majority.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction

endpackage

// File: rtl/rtq_adder_cells.sv
module rtq_half_adder (
    input  logic a_i,
    input  logic b_i,
    output logic sum_o,
    output logic carry_o
);
    assign sum_o   = a_i ^ b_i;
    assign carry_o = a_i & b_i;
endmodule

module rtq_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic sum_o,
    output logic carry_o
);
    assign sum_o   = a_i ^ b_i ^ c_i;
    assign carry_o = rtq_pkg::maj3(a_i, b_i, c_i);
endmodule

// File: rtl/rtq_popcount.sv
// Recursive tree of half and full adders that counts the ones in bits_i.
module rtq_popcount #(
    parameter int N = 9
) (
    input  logic [N-1:0]                     bits_i,
    output logic [rtq_pkg::count_width(N)-1:0] count_o
);
    localparam int CW = rtq_pkg::count_width(N);

    generate
        if (N == 1) begin : g_leaf1
            assign count_o = bits_i;
        end else if (N == 2) begin : g_leaf2
            logic s2, c2;
            rtq_half_adder u_ha (.a_i(bits_i[0]), .b_i(bits_i[1]), .sum_o(s2), .carry_o(c2));
            assign count_o = {c2, s2};
        end else if (N == 3) begin : g_leaf3
            logic s3, c3;
            rtq_full_adder u_fa (.a_i(bits_i[0]), .b_i(bits_i[1]), .c_i(bits_i[2]),
                                 .sum_o(s3), .carry_o(c3));
            assign count_o = {c3, s3};
        end else begin : g_split
            localparam int NL = N / 2;
            localparam int NR = N - NL;
            localparam int WL = rtq_pkg::count_width(NL);
            localparam int WR = rtq_pkg::count_width(NR);

            logic [WL-1:0] hi_cnt;
            logic [WR-1:0] lo_cnt;
            logic [WR-1:0] hi_ext;
            logic [WR:0]   carry;
            logic [WR-1:0] sum;

            rtq_popcount #(.N(NL)) u_hi (.bits_i(bits_i[N-1:NR]), .count_o(hi_cnt));
            rtq_popcount #(.N(NR)) u_lo (.bits_i(bits_i[NR-1:0]), .count_o(lo_cnt));

            assign hi_ext   = WR'(hi_cnt);
            assign carry[0] = 1'b0;

            for (genvar k = 0; k < WR; k++) begin : g_bit
                if (k == 0) begin : g_ha
                    rtq_half_adder u_ha (.a_i(hi_ext[k]), .b_i(lo_cnt[k]),
                                         .sum_o(sum[k]), .carry_o(carry[k+1]));
                end else begin : g_fa
                    rtq_full_adder u_fa (.a_i(hi_ext[k]), .b_i(lo_cnt[k]), .c_i(carry[k]),
                                         .sum_o(sum[k]), .carry_o(carry[k+1]));
                end
            end

            logic [WR:0] total;
            assign total   = {carry[WR], sum};
            assign count_o = total[CW-1:0];
        end
    endgenerate
endmodule

// File: rtl/rtq_carry_chain.sv
// Produces only the carry out of z + ~r + 1, i.e. (z >= r) for unsigned operands.
module rtq_carry_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] z_i,
    input  logic [W-1:0] r_i,
    output logic         ge_o
);
    logic [W-1:0] r_n;
    logic [W:1]   c;

    assign r_n = ~r_i;

    generate
        for (genvar k = 0; k < W; k++) begin : g_stage
            if (k == 0) begin : g_lsb
                // Carry-in is the constant 1, so majority reduces to OR.
                assign c[1] = z_i[0] | r_n[0];
            end else begin : g_maj
                assign c[k+1] = rtq_pkg::maj3(z_i[k], r_n[k], c[k]);
            end
        end
    endgenerate

    assign ge_o = c[W];
endmodule

// File: rtl/rank_threshold_quantizer.sv
module rank_threshold_quantizer #(
    parameter int N           = 9,
    parameter int PIPE_STAGES = 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N-1:0]                         slice_i,
    input  logic [rtq_pkg::count_width(N)-1:0]   rank_i,
    output logic                                 at_least_o
);
    localparam int W = rtq_pkg::count_width(N);

    logic [W-1:0] cnt_comb;
    logic [W-1:0] cnt_use;
    logic [W-1:0] rank_use;

    rtq_popcount #(.N(N)) u_tree (
        .bits_i  (slice_i),
        .count_o (cnt_comb)
    );

    generate
        if (PIPE_STAGES == 1) begin : g_pipe
            logic [W-1:0] cnt_q;
            logic [W-1:0] rank_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    rank_q <= '0;
                end else begin
                    cnt_q  <= cnt_comb;
                    rank_q <= rank_i;
                end
            end

            assign cnt_use  = cnt_q;
            assign rank_use = rank_q;
        end else begin : g_comb
            assign cnt_use  = cnt_comb;
            assign rank_use = rank_i;
        end
    endgenerate

    rtq_carry_chain #(.W(W)) u_cmp (
        .z_i  (cnt_use),
        .r_i  (rank_use),
        .ge_o (at_least_o)
    );
endmodule

// File: rtl/rtq_checker.sv
module rtq_checker #(
    parameter int N           = 9,
    parameter int PIPE_STAGES = 1
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [N-1:0]                       slice_i,
    input logic [rtq_pkg::count_width(N)-1:0] rank_i,
    input logic                               at_least_o
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    generate
        if (PIPE_STAGES == 1) begin : g_pipe_props
            assert_threshold_R1: assert property (@(posedge clk) disable iff (!rst_n)
                seen |-> (at_least_o == ($countones($past(slice_i)) >= int'($past(rank_i)))));

            // R2: a result follows its inputs by exactly one edge
            assert_hold_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $stable(slice_i) && $stable(rank_i) && $past(seen)) |=> $stable(at_least_o));

            assert_rank_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $past(rank_i) == '0) |-> at_least_o);

            assert_rank_too_big_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && int'($past(rank_i)) > N) |-> !at_least_o);

            assert_full_slice_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $past(slice_i) == '1 && int'($past(rank_i)) == N) |-> at_least_o);

            assert_reset_output_R6: assert property (@(posedge clk)
                ($past(!rst_n) && !rst_n) |-> at_least_o);
        end
    endgenerate
endmodule

bind rank_threshold_quantizer rtq_checker #(.N(N), .PIPE_STAGES(PIPE_STAGES)) u_rtq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .slice_i    (slice_i),
    .rank_i     (rank_i),
    .at_least_o (at_least_o)
);

// File: tb/rank_threshold_quantizer_tb.sv
`timescale 1ns/1ps
module rank_threshold_quantizer_tb;
    localparam int N = 9;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [N-1:0] slice = '0;
    logic [W-1:0] rank = '0;
    logic         ge;

    int  applied = 0;
    int  bad = 0;
    bit  finished = 0;

    bit    pend = 0;
    logic  pend_exp;
    string pend_tag;

    always #2.5 clk = ~clk;

    rank_threshold_quantizer #(.N(N), .PIPE_STAGES(1)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slice_i    (slice),
        .rank_i     (rank),
        .at_least_o (ge)
    );

    function automatic logic model_ge(input logic [N-1:0] s, input int r);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(s[i]);
        return (c >= r) ? 1'b1 : 1'b0;
    endfunction

    function automatic string pick_tag(input logic [N-1:0] s, input int r);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(s[i]);
        if (r == 0) return "R3 rank zero";
        if (r > N) return "R4 rank above N";
        if (r == N && c >= N - 1) return "R5 upper boundary";
        return "R1 threshold";
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: slice=%b rank=%0d at_least_o=%b expected %b",
                     tag, slice, rank, act, exp);
        end
    endtask

    // Drive a new vector at a falling edge; compare the previous one there too.
    task automatic step(input logic [N-1:0] s, input int r);
        @(negedge clk);
        if (pend) check(ge, pend_exp, pend_tag);
        slice    = s;
        rank     = W'(r);
        pend     = 1;
        pend_exp = model_ge(s, r);
        pend_tag = pick_tag(s, r);
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) check(ge, pend_exp, pend_tag);
        pend = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: run did not complete, got hang expected completion");
        report();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R6: inputs that would give 0 if captured must not reach the output
        slice = '0;
        rank  = W'(5);
        @(negedge clk);
        check(ge, 1'b1, "R6 reset output");
        @(negedge clk);
        check(ge, 1'b1, "R6 reset output held");
        rst_n = 1'b1;

        // R2: latency of exactly one edge
        slice = '0;
        rank  = W'(1);
        @(negedge clk);
        check(ge, 1'b0, "R2 settled result");
        slice = '1;
        rank  = W'(N);
        #1;
        check(ge, 1'b0, "R2 unchanged before edge");
        @(negedge clk);
        check(ge, 1'b1, "R2 updated after one edge");

        // R5: each slice with N-1 ones at rank N
        for (int k = 0; k < N; k++) begin
            logic [N-1:0] s;
            s = '1;
            s[k] = 1'b0;
            step(s, N);
        end

        // R1, R3, R4, R5: full sweep of slices against every representable rank
        for (int r = 0; r < (1 << W); r++) begin
            for (int s = 0; s < (1 << N); s++) begin
                step(N'(s), r);
            end
        end
        flush();
        report();
    end
endmodule